// File: doc/BRIEF.md
# Asymmetric Windowed Register File

This block is the register file of a small CPU with sixteen architectural registers. Each call depth has its own physical register frame. A 4-bit register index is decoded into one of four slot classes. Private locals belong to the current frame. A small global group is shared by every frame. Outgoing-argument slots are written into the frame one level deeper. Return-value slots are written into the frame one level shallower. Because of this, for arguments and return values, a read of an index does not give back what the same function just wrote to that index.

A call strobe moves the window one frame deeper, so the values the caller placed in its argument slots become the callee's incoming arguments. A return strobe moves the window one frame back, so the callee's return values become readable by the caller. The frames form a circular buffer with a fixed number of entries. A one-cycle overflow flag marks a call made while every frame is occupied, which tells the core that the oldest frame must be spilled to memory. A one-cycle underflow flag marks a return to a frame that is no longer resident. The spill and fill transfers themselves are done outside this block.

The window controller is a three-state machine. The states depend on the resident-frame count. `WIN_BASE` means only the current frame is resident. `WIN_MID` means the count is between one and full. `WIN_FULL` means every frame is held. The transitions are:
- `push`: a call. It takes `WIN_BASE` to `WIN_MID` and `WIN_MID` to `WIN_MID` or `WIN_FULL`.
- `push_spill`: a call in `WIN_FULL`. The state stays `WIN_FULL` and overflow is raised.
- `pop`: a return. It takes `WIN_FULL` or `WIN_MID` one count lower, reaching `WIN_BASE` when the count becomes one.
- `pop_fill`: a return in `WIN_BASE`. The state stays `WIN_BASE` and underflow is raised.
- `hold`: no strobe, or both strobes together.

Top module: `awr_regfile`

## Requirements
- R1: A synchronous reset sets the current level to 0, leaves one frame resident (both flags low), and zeroes global registers 7, 8 and 9.
- R2: Indices 0 to 6 are locals. A write at the current level is read back at that level from the next cycle on. Locals at other levels keep their own values.
- R3: Indices 7 to 9 are one global group. A value written at any level is read at every level.
- R4: Indices 10 to 13 are argument slots. A write lands in the frame of level+1 and does not change what the current level reads at that index. After a call, the new level reads the written value.
- R5: Indices 14 and 15 are return slots. A write lands in the frame of level-1 and does not change what the current level reads at that index. After a return, the previous level reads the written value.
- R6: A call moves the level to (level+1) mod 8, and a return moves it to (level-1) mod 8. If both strobes are high, or neither is, the level does not change.
- R7: A call made while all 8 frames are occupied raises overflow for exactly the following cycle. The level still advances, and the frame count stays at 8.
- R8: A return made while only one frame is resident raises underflow for exactly the following cycle. The level still moves back.
- R9: Both read ports are combinational. A read in the same cycle as a write to the same location returns the old value, and the new value appears after the clock edge.
- R10: A write issued in the same cycle as a call or return strobe uses the level as it stood before the shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_idx_a | input | 4 | Read port A register index |
| rd_data_a | output | 16 | Read port A data (combinational) |
| rd_idx_b | input | 4 | Read port B register index |
| rd_data_b | output | 16 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 16 | Write data |
| call_i | input | 1 | Call strobe: move window one level deeper |
| ret_i | input | 1 | Return strobe: move window one level back |
| level_o | output | 3 | Current level pointer |
| ovf_o | output | 1 | Overflow pulse: oldest frame must be spilled |
| unf_o | output | 1 | Underflow pulse: caller frame must be filled |

## Verification
The index map is exercised with writes to each slot class, each followed by reads at the same level and at neighbouring levels. These show whether a write went to the current, deeper or shallower frame, or to the shared group. A chain of eight calls followed by eight returns walks the machine through every state. It separates the moves that spill or fill from the ordinary ones, and it checks the wrap of the level pointer. Same-cycle patterns, namely a write together with a read of the same index, a write together with a strobe, and both strobes together, distinguish the old-value read, the pre-shift write target and the cancelled shift.

// File: rtl/awr_pkg.sv
package awr_pkg;

    localparam int IDX_W    = 4;
    localparam int N_LOCAL  = 7;
    localparam int N_GLOBAL = 3;
    localparam int N_ARG    = 4;
    localparam int N_RET    = 2;
    localparam int FRAME_WORDS = N_LOCAL + N_ARG + N_RET;
    localparam int GLB_BASE = N_LOCAL;
    localparam int ARG_BASE = GLB_BASE + N_GLOBAL;
    localparam int RET_BASE = ARG_BASE + N_ARG;

    typedef enum logic [1:0] {
        SLOT_LOCAL  = 2'd0,
        SLOT_GLOBAL = 2'd1,
        SLOT_ARG    = 2'd2,
        SLOT_RET    = 2'd3
    } slot_e;

    typedef enum logic [1:0] {
        WIN_BASE = 2'd0,
        WIN_MID  = 2'd1,
        WIN_FULL = 2'd2
    } win_state_e;

    function automatic slot_e slot_of(input logic [IDX_W-1:0] idx);
        if (int'(idx) < GLB_BASE)      return SLOT_LOCAL;
        else if (int'(idx) < ARG_BASE) return SLOT_GLOBAL;
        else if (int'(idx) < RET_BASE) return SLOT_ARG;
        else                           return SLOT_RET;
    endfunction

    function automatic logic [2:0] offset_of(input logic [IDX_W-1:0] idx);
        int r;
        if (int'(idx) < GLB_BASE)      r = int'(idx);
        else if (int'(idx) < ARG_BASE) r = int'(idx) - GLB_BASE;
        else if (int'(idx) < RET_BASE) r = int'(idx) - ARG_BASE;
        else                           r = int'(idx) - RET_BASE;
        return r[2:0];
    endfunction

    // position of a slot inside one physical frame: locals, then args, then rets
    function automatic int frame_word(input slot_e s, input logic [2:0] off);
        unique case (s)
            SLOT_ARG: return N_LOCAL + int'(off);
            SLOT_RET: return N_LOCAL + N_ARG + int'(off);
            default:  return int'(off);
        endcase
    endfunction

endpackage

// File: rtl/awr_window_ctrl.sv
module awr_window_ctrl #(
    parameter int LEVELS = 8,
    localparam int LVL_W = $clog2(LEVELS),
    localparam int OCC_W = $clog2(LEVELS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             call_i,
    input  logic             ret_i,
    output logic [LVL_W-1:0] cur_lvl_o,
    output logic [LVL_W-1:0] nxt_lvl_o,
    output logic [LVL_W-1:0] prv_lvl_o,
    output logic             ovf_o,
    output logic             unf_o
);
    import awr_pkg::*;

    localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(LEVELS - 1);
    localparam logic [OCC_W-1:0] OCC_ONE = OCC_W'(1);
    localparam logic [OCC_W-1:0] OCC_MAX = OCC_W'(LEVELS);

    win_state_e       state_q, state_d;
    logic [OCC_W-1:0] occ_q, occ_d;
    logic [LVL_W-1:0] lvl_q, lvl_d;
    logic             ovf_d, unf_d;
    logic             do_call, do_ret;

    assign do_call = call_i & ~ret_i;
    assign do_ret  = ret_i & ~call_i;

    assign nxt_lvl_o = (lvl_q == LVL_TOP) ? '0 : lvl_q + 1'b1;
    assign prv_lvl_o = (lvl_q == '0) ? LVL_TOP : lvl_q - 1'b1;
    assign cur_lvl_o = lvl_q;

    // next-state logic
    always_comb begin
        occ_d   = occ_q;
        lvl_d   = lvl_q;
        ovf_d   = 1'b0;
        unf_d   = 1'b0;
        if (do_call) begin
            lvl_d = nxt_lvl_o;
            unique case (state_q)
                WIN_FULL: ovf_d = 1'b1;            // push_spill
                default:  occ_d = occ_q + 1'b1;    // push
            endcase
        end else if (do_ret) begin
            lvl_d = prv_lvl_o;
            unique case (state_q)
                WIN_BASE: unf_d = 1'b1;            // pop_fill
                default:  occ_d = occ_q - 1'b1;    // pop
            endcase
        end
        if (occ_d == OCC_ONE)      state_d = WIN_BASE;
        else if (occ_d == OCC_MAX) state_d = WIN_FULL;
        else                       state_d = WIN_MID;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WIN_BASE;
            occ_q   <= OCC_ONE;
            lvl_q   <= '0;
        end else begin
            state_q <= state_d;
            occ_q   <= occ_d;
            lvl_q   <= lvl_d;
        end
    end

    // output flags
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_o <= 1'b0;
            unf_o <= 1'b0;
        end else begin
            ovf_o <= ovf_d;
            unf_o <= unf_d;
        end
    end

    assert_occ_range_R7: assert property (@(posedge clk) disable iff (rst)
        (occ_q >= OCC_ONE) && (occ_q <= OCC_MAX));

    assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> ($past(call_i) && !$past(ret_i) && ($past(state_q) == WIN_FULL)));

    assert_unf_cause_R8: assert property (@(posedge clk) disable iff (rst)
        unf_o |-> ($past(ret_i) && !$past(call_i) && ($past(state_q) == WIN_BASE)));

    assert_level_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (call_i == ret_i) |=> $stable(lvl_q));

endmodule

// File: rtl/awr_global_store.sv
module awr_global_store #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [2:0]    wr_off,
    input  logic [DW-1:0] wr_data,
    input  logic [2:0]    rd_off_a,
    input  logic [2:0]    rd_off_b,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b
);
    import awr_pkg::*;

    logic [DW-1:0] greg [N_GLOBAL];

    for (genvar g = 0; g < N_GLOBAL; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                greg[g] <= '0;
            else if (we && (int'(wr_off) == g))
                greg[g] <= wr_data;
        end
    end

    assign rd_a = (int'(rd_off_a) < N_GLOBAL) ? greg[rd_off_a[1:0]] : '0;
    assign rd_b = (int'(rd_off_b) < N_GLOBAL) ? greg[rd_off_b[1:0]] : '0;

    assert_global_write_R3: assert property (@(posedge clk) disable iff (rst)
        (we && (int'(wr_off) < N_GLOBAL)) |=> (greg[$past(wr_off[1:0])] == $past(wr_data)));

endmodule

// File: rtl/awr_frame_store.sv
module awr_frame_store #(
    parameter int DW     = 16,
    parameter int LEVELS = 8,
    localparam int LVL_W = $clog2(LEVELS),
    localparam int DEPTH = LEVELS * awr_pkg::FRAME_WORDS,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LVL_W-1:0]  wr_lvl,
    input  awr_pkg::slot_e    wr_slot,
    input  logic [2:0]        wr_off,
    input  logic [DW-1:0]     wr_data,
    input  logic [LVL_W-1:0]  rd_lvl,
    input  awr_pkg::slot_e    rd_slot [2],
    input  logic [2:0]        rd_off  [2],
    output logic [DW-1:0]     rd_data [2]
);
    import awr_pkg::*;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_addr;

    assign wr_addr = AW'(int'(wr_lvl) * FRAME_WORDS + frame_word(wr_slot, wr_off));

    always_ff @(posedge clk) begin
        if (we)
            mem[wr_addr] <= wr_data;
    end

    for (genvar p = 0; p < 2; p++) begin : g_rport
        logic [AW-1:0] rd_addr;
        assign rd_addr    = AW'(int'(rd_lvl) * FRAME_WORDS + frame_word(rd_slot[p], rd_off[p]));
        assign rd_data[p] = mem[rd_addr];
    end

endmodule

// File: rtl/awr_regfile.sv
module awr_regfile #(
    parameter int DW     = 16,
    parameter int LEVELS = 8,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       rd_idx_a,
    output logic [DW-1:0]    rd_data_a,
    input  logic [3:0]       rd_idx_b,
    output logic [DW-1:0]    rd_data_b,
    input  logic             wr_en,
    input  logic [3:0]       wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic             call_i,
    input  logic             ret_i,
    output logic [LVL_W-1:0] level_o,
    output logic             ovf_o,
    output logic             unf_o
);
    import awr_pkg::*;

    logic [LVL_W-1:0] cur_lvl, nxt_lvl, prv_lvl, wr_lvl;
    slot_e            wr_slot;
    logic [2:0]       wr_off;
    slot_e            rd_slot [2];
    logic [2:0]       rd_off  [2];
    logic [DW-1:0]    frm_rd  [2];
    logic [DW-1:0]    glb_rd_a, glb_rd_b;
    logic             frm_we, glb_we;

    awr_window_ctrl #(.LEVELS(LEVELS)) u_win (
        .clk       (clk),
        .rst       (rst),
        .call_i    (call_i),
        .ret_i     (ret_i),
        .cur_lvl_o (cur_lvl),
        .nxt_lvl_o (nxt_lvl),
        .prv_lvl_o (prv_lvl),
        .ovf_o     (ovf_o),
        .unf_o     (unf_o)
    );

    assign wr_slot = slot_of(wr_idx);
    assign wr_off  = offset_of(wr_idx);
    assign rd_slot[0] = slot_of(rd_idx_a);
    assign rd_slot[1] = slot_of(rd_idx_b);
    assign rd_off[0]  = offset_of(rd_idx_a);
    assign rd_off[1]  = offset_of(rd_idx_b);

    // write target frame: asymmetric for argument and return slots
    always_comb begin
        unique case (wr_slot)
            SLOT_ARG: wr_lvl = nxt_lvl;
            SLOT_RET: wr_lvl = prv_lvl;
            default:  wr_lvl = cur_lvl;
        endcase
    end

    assign frm_we = wr_en && (wr_slot != SLOT_GLOBAL);
    assign glb_we = wr_en && (wr_slot == SLOT_GLOBAL);

    awr_frame_store #(.DW(DW), .LEVELS(LEVELS)) u_frames (
        .clk     (clk),
        .we      (frm_we),
        .wr_lvl  (wr_lvl),
        .wr_slot (wr_slot),
        .wr_off  (wr_off),
        .wr_data (wr_data),
        .rd_lvl  (cur_lvl),
        .rd_slot (rd_slot),
        .rd_off  (rd_off),
        .rd_data (frm_rd)
    );

    awr_global_store #(.DW(DW)) u_globals (
        .clk      (clk),
        .rst      (rst),
        .we       (glb_we),
        .wr_off   (wr_off),
        .wr_data  (wr_data),
        .rd_off_a (rd_off[0]),
        .rd_off_b (rd_off[1]),
        .rd_a     (glb_rd_a),
        .rd_b     (glb_rd_b)
    );

    assign rd_data_a = (rd_slot[0] == SLOT_GLOBAL) ? glb_rd_a : frm_rd[0];
    assign rd_data_b = (rd_slot[1] == SLOT_GLOBAL) ? glb_rd_b : frm_rd[1];
    assign level_o   = cur_lvl;

    assert_local_rdback_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_idx < 4'd7) && !call_i && !ret_i)
        |=> ((rd_idx_a != $past(wr_idx)) || (rd_data_a == $past(wr_data))));

endmodule

// File: tb/awr_regfile_tb.sv
module awr_regfile_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  rd_idx_a, rd_idx_b, wr_idx;
    logic [15:0] rd_data_a, rd_data_b, wr_data;
    logic        wr_en, call_i, ret_i;
    logic [2:0]  level_o;
    logic        ovf_o, unf_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    awr_regfile u_dut (
        .clk(clk), .rst(rst),
        .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
        .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .call_i(call_i), .ret_i(ret_i),
        .level_o(level_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 1'b0; call_i = 1'b0; ret_i = 1'b0;
        wr_idx = '0; wr_data = '0; rd_idx_a = '0; rd_idx_b = '0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic wr(input logic [3:0] idx, input logic [15:0] d);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [15:0] d);
        rd_idx_a = idx;
        #1;
        d = rd_data_a;
    endtask

    task automatic do_call();
        call_i = 1'b1; step(); call_i = 1'b0;
    endtask

    task automatic do_ret();
        ret_i = 1'b1; step(); ret_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        do_reset();
        check("R1 level", 16'(level_o), 16'd0);
        check("R1 ovf", 16'(ovf_o), 16'd0);
        check("R1 unf", 16'(unf_o), 16'd0);
        for (int i = 7; i <= 9; i++) begin
            rd(4'(i), v);
            check("R1 global zero", v, 16'h0000);
        end
    endtask

    task automatic t_locals();
        logic [15:0] v;
        do_reset();
        wr(4'd3, 16'hA0A0);
        wr(4'd6, 16'h6666);
        do_call();
        wr(4'd3, 16'hB1B1);
        rd(4'd3, v); check("R2 local level1", v, 16'hB1B1);
        do_ret();
        rd(4'd3, v); check("R2 local level0 kept", v, 16'hA0A0);
        rd(4'd6, v); check("R2 local idx6", v, 16'h6666);
    endtask

    task automatic t_globals();
        logic [15:0] v;
        do_reset();
        wr(4'd8, 16'hAAAA);
        do_call();
        rd(4'd8, v); check("R3 global seen deeper", v, 16'hAAAA);
        wr(4'd9, 16'hBBBB);
        do_ret();
        rd(4'd9, v); check("R3 global seen shallower", v, 16'hBBBB);
    endtask

    task automatic t_args();
        logic [15:0] v;
        do_reset();
        wr(4'd10, 16'hC0C0);
        wr(4'd13, 16'hC3C3);
        do_call();
        check("R6 level after call", 16'(level_o), 16'd1);
        rd(4'd10, v); check("R4 arg received", v, 16'hC0C0);
        wr(4'd10, 16'hD0D0);
        rd(4'd10, v); check("R4 arg write not local", v, 16'hC0C0);
        rd(4'd13, v); check("R4 arg idx13", v, 16'hC3C3);
        do_call();
        rd(4'd10, v); check("R4 arg next level", v, 16'hD0D0);
    endtask

    task automatic t_rets();
        logic [15:0] v;
        do_reset();
        do_call(); do_call();
        wr(4'd14, 16'hE4E4);
        wr(4'd15, 16'hE5E5);
        do_ret();
        check("R6 level after return", 16'(level_o), 16'd1);
        rd(4'd14, v); check("R5 ret received", v, 16'hE4E4);
        wr(4'd15, 16'hF5F5);
        rd(4'd15, v); check("R5 ret write not local", v, 16'hE5E5);
        do_ret();
        rd(4'd15, v); check("R5 ret at level0", v, 16'hF5F5);
    endtask

    task automatic t_same_cycle();
        do_reset();
        wr(4'd5, 16'h1234);
        wr_en = 1'b1; wr_idx = 4'd5; wr_data = 16'h5678;
        rd_idx_a = 4'd5; rd_idx_b = 4'd5;
        #1;
        check("R9 port A old value", rd_data_a, 16'h1234);
        check("R9 port B old value", rd_data_b, 16'h1234);
        step();
        wr_en = 1'b0;
        #1;
        check("R9 port A new value", rd_data_a, 16'h5678);
        check("R9 port B new value", rd_data_b, 16'h5678);
    endtask

    task automatic t_strobe_write();
        logic [15:0] v;
        do_reset();
        wr_en = 1'b1; wr_idx = 4'd2; wr_data = 16'h0202; call_i = 1'b1;
        step();
        wr_en = 1'b1; wr_idx = 4'd2; wr_data = 16'h1212; call_i = 1'b0;
        step();
        wr_en = 1'b1; wr_idx = 4'd14; wr_data = 16'h7E7E; ret_i = 1'b1;
        step();
        wr_en = 1'b0; ret_i = 1'b0;
        check("R10 level back to 0", 16'(level_o), 16'd0);
        rd(4'd2, v);  check("R10 call+write hit old level", v, 16'h0202);
        rd(4'd14, v); check("R10 ret+write hit pre-shift target", v, 16'h7E7E);
        wr_en = 1'b1; wr_idx = 4'd11; wr_data = 16'hABCD; call_i = 1'b1;
        step();
        wr_en = 1'b0; call_i = 1'b0;
        rd(4'd11, v); check("R10 call+arg write", v, 16'hABCD);
        rd(4'd2, v);  check("R10 call+write level1 local", v, 16'h1212);
        call_i = 1'b1; ret_i = 1'b1;
        step();
        call_i = 1'b0; ret_i = 1'b0;
        check("R6 both strobes hold", 16'(level_o), 16'd1);
        check("R6 both strobes no ovf", 16'(ovf_o), 16'd0);
        check("R6 both strobes no unf", 16'(unf_o), 16'd0);
    endtask

    task automatic t_ovf_unf();
        do_reset();
        for (int i = 1; i <= 7; i++) begin
            do_call();
            check("R6 call level", 16'(level_o), 16'(i));
            check("R7 no early ovf", 16'(ovf_o), 16'd0);
        end
        do_call();
        check("R6 level wraps", 16'(level_o), 16'd0);
        check("R7 ovf raised", 16'(ovf_o), 16'd1);
        step();
        check("R7 ovf one cycle", 16'(ovf_o), 16'd0);
        for (int i = 7; i >= 1; i--) begin
            do_ret();
            check("R6 return level", 16'(level_o), 16'(i));
            check("R8 no early unf", 16'(unf_o), 16'd0);
        end
        do_ret();
        check("R8 level after fill return", 16'(level_o), 16'd0);
        check("R8 unf raised", 16'(unf_o), 16'd1);
        step();
        check("R8 unf one cycle", 16'(unf_o), 16'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_locals();
        t_globals();
        t_args();
        t_rets();
        t_same_cycle();
        t_strobe_write();
        t_ovf_unf();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule